// File: doc/BRIEF.md
# Tri-Port Latched Bus Exchanger

This block connects one host-side port (A) to two memory-side ports: B1 for the even bank and B2 for the odd bank. All three ports are `WIDTH` bits wide, 12 by default. Four storage cells sit between the ports, and each one has its own enable. Two cells carry A toward B1 and B2. The other two carry B1 and B2 back toward A. One select line, applied after the two return cells, decides which of them drives A. Because of this split, A can broadcast to both banks at once while each bank keeps its own captured copy. The split also lets one bank be read while the other is being written.

Each storage cell has two modes. In PASS mode its enable is high and the output follows the input. In HOLD mode its enable is low and the output shows the captured value. A cell moves from PASS to HOLD when its enable falls and moves back when the enable rises. Each port driver also has two modes. In PORT_DRIVE its active-low output enable is low, so the driver presents data and raises the matching `*_oe`. In PORT_FLOAT the driver drops `*_oe` and drives zeros.

The parameter `USE_CLOCK` sets how each cell stores data:
- With `USE_CLOCK=1`, each cell is a register that samples on every rising `clk` edge while its enable is high. The PASS bypass gives the same transparency as a latch.
- With `USE_CLOCK=0`, each cell is a true level-sensitive latch.

Every bidirectional pin is split into `*_in`, `*_out` and `*_oe` vectors, so tri-state pads stay outside the block.

Top module: `bx_exchanger`

## Requirements
- R1: An active-low asynchronous reset (`rst_n`) clears all four stored values to zero. After reset, with all latch enables low and all output enables asserted, every port output reads zero.
- R2: While `le_a1` is high, `b1_out` equals `a_in` in the same cycle, provided `oe_b1_n` is low.
- R3: After `le_a1` falls, `b1_out` keeps the `a_in` value present at the last rising `clk` edge at which `le_a1` was high. It keeps that value however `a_in` changes, until `le_a1` is raised again.
- R4: The A-to-B2 cell, gated by `le_a2`, follows the rules of R2 and R3 independently of the A-to-B1 cell. Both B ports may be loaded from A in the same cycle.
- R5: The B1-to-A cell is gated by `le_1a` and the B2-to-A cell by `le_2a`. Each is transparent while its enable is high and holds its captured value while the enable is low, under the same capture rule as R3.
- R6: With `sel_b1`=1, `a_out` shows the B1-to-A cell output. With `sel_b1`=0, it shows the B2-to-A cell output. Changing `sel_b1` never alters either stored value.
- R7: While `oe_a_n` is high, `a_oe` is 0 and `a_out` is all zeros, whatever the other inputs are.
- R8: `oe_b1_n` and `oe_b2_n` act independently. While either is high, its `*_oe` is 0 and its `*_out` is zero, and the other B port is unaffected.
- R9: While an active-low output enable is low, the matching `*_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the cells when USE_CLOCK=1 |
| rst_n | input | 1 | Asynchronous active-low reset of all stored values |
| a_in | input | WIDTH | Data arriving on port A |
| a_out | output | WIDTH | Data driven onto port A |
| a_oe | output | 1 | Port A driver enable, active high |
| b1_in | input | WIDTH | Data arriving on port B1 (even bank) |
| b1_out | output | WIDTH | Data driven onto port B1 |
| b1_oe | output | 1 | Port B1 driver enable, active high |
| b2_in | input | WIDTH | Data arriving on port B2 (odd bank) |
| b2_out | output | WIDTH | Data driven onto port B2 |
| b2_oe | output | 1 | Port B2 driver enable, active high |
| le_a1 | input | 1 | Enable of the A-to-B1 cell |
| le_a2 | input | 1 | Enable of the A-to-B2 cell |
| le_1a | input | 1 | Enable of the B1-to-A cell |
| le_2a | input | 1 | Enable of the B2-to-A cell |
| sel_b1 | input | 1 | Return path select: 1 picks B1-to-A, 0 picks B2-to-A |
| oe_a_n | input | 1 | Port A output enable, active low |
| oe_b1_n | input | 1 | Port B1 output enable, active low |
| oe_b2_n | input | 1 | Port B2 output enable, active low |

## Verification
The bench builds the block with its defaults: `WIDTH=12` and `USE_CLOCK=1`. With those settings every capture happens at a known clock edge, so the held value after an enable falls can be predicted exactly. Twelve bits are wide enough that random data makes a wrong source or a stale copy show up at once. The randomised enables and selects cover every mix of PASS and HOLD across the four cells, including both B ports loading together.

// File: rtl/bx_pkg.sv
package bx_pkg;

    // Operating mode of a single storage cell
    typedef enum logic {
        CELL_HOLD = 1'b0,
        CELL_PASS = 1'b1
    } cell_mode_e;

    // Operating mode of one port driver
    typedef enum logic {
        PORT_FLOAT = 1'b0,
        PORT_DRIVE = 1'b1
    } port_mode_e;

    // Positions of the four cells in the cell array
    localparam int unsigned NUM_CELLS = 4;
    localparam int unsigned IDX_A_B1  = 0;
    localparam int unsigned IDX_A_B2  = 1;
    localparam int unsigned IDX_B1_A  = 2;
    localparam int unsigned IDX_B2_A  = 3;

endpackage

// File: rtl/bx_latch_cell.sv
module bx_latch_cell
    import bx_pkg::*;
#(
    parameter int unsigned WIDTH     = 12,
    parameter bit          USE_CLOCK = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stored;
    cell_mode_e       mode;

    // Storage element: a sampled register or a true latch, chosen by parameter
    generate
        if (USE_CLOCK) begin : g_sampled
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stored <= '0;
                end else if (en) begin
                    stored <= d;
                end
            end
        end else begin : g_level
            always_latch begin
                if (!rst_n) begin
                    stored = '0;
                end else if (en) begin
                    stored = d;
                end
            end
        end
    endgenerate

    // Mode decode: the enable level chooses between PASS and HOLD
    always_comb begin
        mode = en ? CELL_PASS : CELL_HOLD;
    end

    // Output: the same data path in both storage variants
    always_comb begin
        unique case (mode)
            CELL_PASS: q = d;
            CELL_HOLD: q = stored;
        endcase
    end

endmodule

// File: rtl/bx_port_drive.sv
module bx_port_drive
    import bx_pkg::*;
#(
    parameter int unsigned WIDTH = 12
) (
    input  logic             oe_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic             oe
);

    port_mode_e mode;

    // Decode the active-low enable into a driver mode
    always_comb begin
        mode = oe_n ? PORT_FLOAT : PORT_DRIVE;
    end

    // A floating port drives zeros so the pad wrapper sees defined data
    always_comb begin
        unique case (mode)
            PORT_DRIVE: begin
                q  = d;
                oe = 1'b1;
            end
            PORT_FLOAT: begin
                q  = '0;
                oe = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bx_exchanger.sv
module bx_exchanger
    import bx_pkg::*;
#(
    parameter int unsigned WIDTH     = 12,
    parameter bit          USE_CLOCK = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b1_in,
    output logic [WIDTH-1:0] b1_out,
    output logic             b1_oe,
    input  logic [WIDTH-1:0] b2_in,
    output logic [WIDTH-1:0] b2_out,
    output logic             b2_oe,
    input  logic             le_a1,
    input  logic             le_a2,
    input  logic             le_1a,
    input  logic             le_2a,
    input  logic             sel_b1,
    input  logic             oe_a_n,
    input  logic             oe_b1_n,
    input  logic             oe_b2_n
);

    localparam int unsigned N = NUM_CELLS;

    logic [WIDTH-1:0] cell_d [N];
    logic [WIDTH-1:0] cell_q [N];
    logic [N-1:0]     cell_en;
    logic [WIDTH-1:0] ret_sel;

    // Wire each cell to its source port and enable
    always_comb begin
        cell_d[IDX_A_B1]  = a_in;
        cell_d[IDX_A_B2]  = a_in;
        cell_d[IDX_B1_A]  = b1_in;
        cell_d[IDX_B2_A]  = b2_in;
        cell_en[IDX_A_B1] = le_a1;
        cell_en[IDX_A_B2] = le_a2;
        cell_en[IDX_B1_A] = le_1a;
        cell_en[IDX_B2_A] = le_2a;
    end

    generate
        for (genvar i = 0; i < N; i++) begin : g_cell
            bx_latch_cell #(
                .WIDTH     (WIDTH),
                .USE_CLOCK (USE_CLOCK)
            ) u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (cell_en[i]),
                .d     (cell_d[i]),
                .q     (cell_q[i])
            );
        end
    endgenerate

    // Return path select, placed after the two B-to-A cells
    always_comb begin
        ret_sel = sel_b1 ? cell_q[IDX_B1_A] : cell_q[IDX_B2_A];
    end

    bx_port_drive #(.WIDTH(WIDTH)) u_drv_a (
        .oe_n (oe_a_n),
        .d    (ret_sel),
        .q    (a_out),
        .oe   (a_oe)
    );

    bx_port_drive #(.WIDTH(WIDTH)) u_drv_b1 (
        .oe_n (oe_b1_n),
        .d    (cell_q[IDX_A_B1]),
        .q    (b1_out),
        .oe   (b1_oe)
    );

    bx_port_drive #(.WIDTH(WIDTH)) u_drv_b2 (
        .oe_n (oe_b2_n),
        .d    (cell_q[IDX_A_B2]),
        .q    (b2_out),
        .oe   (b2_oe)
    );

endmodule

// File: rtl/bx_exchanger_chk.sv
module bx_exchanger_chk #(
    parameter int unsigned WIDTH = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] a_out,
    input logic             a_oe,
    input logic [WIDTH-1:0] b1_in,
    input logic [WIDTH-1:0] b1_out,
    input logic             b1_oe,
    input logic [WIDTH-1:0] b2_in,
    input logic [WIDTH-1:0] b2_out,
    input logic             b2_oe,
    input logic             le_a1,
    input logic             le_a2,
    input logic             le_1a,
    input logic             le_2a,
    input logic             sel_b1,
    input logic             oe_a_n,
    input logic             oe_b1_n,
    input logic             oe_b2_n
);

    // R2: the A-to-B1 cell passes A straight through while enabled
    a_r2_a1_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (le_a1 && !oe_b1_n) |-> (b1_out == a_in));

    // R3: with the enable low across two edges, B1 output does not move
    a_r3_a1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_a1 && $past(!le_a1) && !oe_b1_n && $past(!oe_b1_n)) |-> $stable(b1_out));

    // R4: the A-to-B2 cell passes and holds independently
    a_r4_a2_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (le_a2 && !oe_b2_n) |-> (b2_out == a_in));

    a_r4_a2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_a2 && $past(!le_a2) && !oe_b2_n && $past(!oe_b2_n)) |-> $stable(b2_out));

    // R5 and R6: an open return cell, once selected, reaches A
    a_r5_b1_return: assert property (@(posedge clk) disable iff (!rst_n)
        (le_1a && sel_b1 && !oe_a_n) |-> (a_out == b1_in));

    a_r6_b2_return: assert property (@(posedge clk) disable iff (!rst_n)
        (le_2a && !sel_b1 && !oe_a_n) |-> (a_out == b2_in));

    // R7: port A floats while its enable is deasserted
    a_r7_a_float: assert property (@(posedge clk) disable iff (!rst_n)
        oe_a_n |-> (!a_oe && a_out == '0));

    // R8: each B port floats on its own enable
    a_r8_b1_float: assert property (@(posedge clk) disable iff (!rst_n)
        oe_b1_n |-> (!b1_oe && b1_out == '0));

    a_r8_b2_float: assert property (@(posedge clk) disable iff (!rst_n)
        oe_b2_n |-> (!b2_oe && b2_out == '0));

    // R9: an asserted enable raises every matching driver enable
    a_r9_drive_on: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_a_n |-> a_oe) and (!oe_b1_n |-> b1_oe) and (!oe_b2_n |-> b2_oe));

endmodule

bind bx_exchanger bx_exchanger_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/bx_exchanger_tb.sv
module bx_exchanger_tb;

    localparam int unsigned W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
    logic [W-1:0] a_out, b1_out, b2_out;
    logic         a_oe, b1_oe, b2_oe;
    logic         le_a1 = 0, le_a2 = 0, le_1a = 0, le_2a = 0, sel_b1 = 0;
    logic         oe_a_n = 1, oe_b1_n = 1, oe_b2_n = 1;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // Expected stored values, updated from the capture rule
    logic [W-1:0] m_a1, m_a2, m_1a, m_2a;

    always #2.5 clk = ~clk;

    bx_exchanger #(.WIDTH(W), .USE_CLOCK(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b1_in(b1_in), .b1_out(b1_out), .b1_oe(b1_oe),
        .b2_in(b2_in), .b2_out(b2_out), .b2_oe(b2_oe),
        .le_a1(le_a1), .le_a2(le_a2), .le_1a(le_1a), .le_2a(le_2a),
        .sel_b1(sel_b1), .oe_a_n(oe_a_n), .oe_b1_n(oe_b1_n), .oe_b2_n(oe_b2_n)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_a1 <= '0; m_a2 <= '0; m_1a <= '0; m_2a <= '0;
        end else begin
            if (le_a1) m_a1 <= a_in;
            if (le_a2) m_a2 <= a_in;
            if (le_1a) m_1a <= b1_in;
            if (le_2a) m_2a <= b2_in;
        end
    end

    function automatic logic [W-1:0] cell_out(input logic en, input logic [W-1:0] d,
                                              input logic [W-1:0] st);
        return en ? d : st;
    endfunction

    function automatic logic [W-1:0] port_out(input logic oe_n, input logic [W-1:0] d);
        return oe_n ? '0 : d;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare every output against the model
    task automatic check_all(input string req);
        logic [W-1:0] ret;
        ret = sel_b1 ? cell_out(le_1a, b1_in, m_1a) : cell_out(le_2a, b2_in, m_2a);
        chk({req, " a_out"},  a_out,  port_out(oe_a_n, ret));
        chk({req, " b1_out"}, b1_out, port_out(oe_b1_n, cell_out(le_a1, a_in, m_a1)));
        chk({req, " b2_out"}, b2_out, port_out(oe_b2_n, cell_out(le_a2, a_in, m_a2)));
        chk({req, " oe"}, {{(W-3){1'b0}}, a_oe, b1_oe, b2_oe},
            {{(W-3){1'b0}}, ~oe_a_n, ~oe_b1_n, ~oe_b2_n});
    endtask

    // Inputs change at the falling edge; outputs are checked 1 ns later
    task automatic settle();
        @(negedge clk);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R1: cleared stores visible once drivers are on
        oe_a_n = 0; oe_b1_n = 0; oe_b2_n = 0;
        a_in = 12'hABC; b1_in = 12'h123; b2_in = 12'h456;
        #1;
        chk("R1 b1 reset", b1_out, 12'h000);
        chk("R1 b2 reset", b2_out, 12'h000);
        chk("R1 a reset",  a_out,  12'h000);
        sel_b1 = 1; #1;
        chk("R1 a reset sel1", a_out, 12'h000);

        // R2 transparency and R4 simultaneous load
        settle();
        le_a1 = 1; le_a2 = 1; a_in = 12'h5A5; #1;
        chk("R2 b1 pass", b1_out, 12'h5A5);
        chk("R4 b2 pass", b2_out, 12'h5A5);
        a_in = 12'h3C3; #1;
        chk("R2 b1 follows", b1_out, 12'h3C3);

        // R3 hold: drop the enable, then change the input
        settle();
        le_a1 = 0; a_in = 12'h0F0; #1;
        chk("R3 b1 held", b1_out, 12'h3C3);
        chk("R4 b2 still passing", b2_out, 12'h0F0);
        settle();
        le_a2 = 0; a_in = 12'hFFF; #1;
        chk("R4 b2 held", b2_out, 12'h0F0);
        chk("R3 b1 held again", b1_out, 12'h3C3);

        // R5 and R6: load both return cells, then swap the select
        settle();
        le_1a = 1; le_2a = 1; b1_in = 12'h111; b2_in = 12'h222; sel_b1 = 1; #1;
        chk("R5 b1 return pass", a_out, 12'h111);
        settle();
        le_1a = 0; le_2a = 0; b1_in = 12'h999; b2_in = 12'h888; #1;
        chk("R5 b1 return held", a_out, 12'h111);
        sel_b1 = 0; #1;
        chk("R6 sel b2", a_out, 12'h222);
        sel_b1 = 1; #1;
        chk("R6 sel back b1", a_out, 12'h111);

        // R7, R8, R9: float each port independently
        settle();
        oe_a_n = 1; #1;
        chk("R7 a float", a_out, 12'h000);
        chk("R7 a_oe", {11'd0, a_oe}, 12'h000);
        oe_b1_n = 1; #1;
        chk("R8 b1 float", b1_out, 12'h000);
        chk("R8 b2 unaffected", b2_out, 12'h0F0);
        chk("R9 b2_oe", {11'd0, b2_oe}, 12'h001);
        oe_b1_n = 0; oe_b2_n = 1; #1;
        chk("R8 b2 float", b2_out, 12'h000);
        chk("R8 b1 unaffected", b1_out, 12'h3C3);

        // Random mix of all controls
        for (int i = 0; i < 3000; i++) begin
            settle();
            a_in  = W'($urandom);
            b1_in = W'($urandom);
            b2_in = W'($urandom);
            {le_a1, le_a2, le_1a, le_2a} = 4'($urandom);
            sel_b1 = 1'($urandom);
            {oe_a_n, oe_b1_n, oe_b2_n} = 3'($urandom) & 3'($urandom);
            #1;
            check_all("R2-R9 random");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule